// File: doc/BRIEF.md
# Multi-Waveform Numerically Controlled Oscillator

This block is a direct digital synthesis core. An N-bit phase register advances by a programmable step on every clock and wraps modulo 2^N. A phase offset is added to the running phase, the sum is cut down to its top M bits, and that M-bit phase feeds a shaping stage. The shaping stage turns the phase into a DAC code that is a ramp, a triangle or a sine, chosen by a two-bit select.

The ramp is the truncated phase itself. The triangle reuses the same ramp through a row of XOR gates. A single flag bit controls those gates and flips every time the phase register wraps, so the code climbs during one wrap and falls during the next. One triangle period therefore spans two wraps, and its fundamental is half the ramp frequency for the same step. The sine comes from a table that holds one full period. The table is computed at elaboration with integer arithmetic, so no data file is needed.

Each time the phase register carries out of its top bit, a wrap strobe is raised for one cycle. Changes to the step, the offset and the select act on the next clock and leave the running phase untouched. The DAC and the analog chain behind it are not part of this block.

Top module: `dds_wavegen`

## Requirements
- R1: A synchronous reset clears the phase register and the triangle flag, and drives `sample_o` and `wrap_o` to 0.
- R2: On every clock the phase register adds `inc_i` modulo 2^N. A new `inc_i` value takes effect at the next clock edge and does not reset the phase.
- R3: `wrap_o` is 1 in exactly the cycle after an addition that carried out of bit N-1, and 0 otherwise. This includes a carry that starts in the discarded low bits.
- R4: The sampled phase is (phase register + `phase_off_i`) mod 2^N, truncated to bits N-1 down to N-M.
- R5: With select 0 (ramp), or with the spare code 3, the output code equals the truncated phase.
- R6: With select 1 (triangle), the output code equals the truncated phase XOR M copies of the flag. The flag toggles on each wrap, so the code rises over one wrap and falls over the next.
- R7: With select 2 (sine), for truncated phase p the output code is 2^(M-1) + round((2^(M-1)-1)·sin(2πp/2^M)), within ±1. The code lies between 1 and 2^M-1.
- R8: The output is registered with one cycle of latency. The code after an edge is computed from the phase, flag, offset and select that were present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| inc_i | input | N | Phase step added every clock |
| phase_off_i | input | N | Phase offset added before truncation |
| wave_sel_i | input | 2 | 0 ramp, 1 triangle, 2 sine, 3 ramp |
| sample_o | output | M | Registered DAC code |
| wrap_o | output | 1 | One-cycle strobe after a phase wrap |

## Verification
The bench goes after the wrap that starts from a carry in the discarded low bits. A design that takes its strobe from the truncated bits alone would miss that wrap, and the triangle would then turn around late. A per-cycle reference model follows select and step changes made mid-run; a design that reset the phase on such a change, or applied it a cycle late, would fall out of step with the model at once. The sine sweep visits every table entry and the quadrant edges (codes 512, 1023 and 1 for phases 0, 256 and 768), which exposes a mirrored or mis-signed quadrant. A largest-value step that carries on almost every clock shows whether the strobe repeats correctly.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  typedef enum logic [1:0] {
    WAVE_SAW     = 2'd0,
    WAVE_TRI     = 2'd1,
    WAVE_SINE    = 2'd2,
    WAVE_SAW_ALT = 2'd3
  } wave_e;

  // Fixed-point fraction width used by the table builder
  localparam int unsigned TBL_FRAC = 28;
  // pi scaled by 2^TBL_FRAC
  localparam longint TBL_PI_Q = 64'sd843314857;

endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] inc_i,
  output logic [N-1:0] acc_o,
  output logic         wrap_o
);

  logic [N-1:0] acc_q;
  logic [N:0]   sum_w;
  logic         past_ok_q;

  // the carry out of the top bit is the wrap event
  assign sum_w  = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = sum_w[N];
  assign acc_o  = acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      acc_q     <= sum_w[N-1:0];
      past_ok_q <= 1'b1;
    end
  end

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok_q |-> acc_q == $past(acc_q) + $past(inc_i)); // R2

endmodule

// File: rtl/dds_tri_flag.sv
`timescale 1ns/1ps
module dds_tri_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wrap_i,
  output logic flag_o
);

  logic flag_q;
  logic past_ok_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      flag_q    <= flag_q ^ wrap_i;
      past_ok_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok_q |-> ((flag_q != $past(flag_q)) == $past(wrap_i))); // R6

endmodule

// File: rtl/dds_sine_rom.sv
`timescale 1ns/1ps
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int unsigned M = 10
) (
  input  logic [M-1:0] addr_i,
  output logic [M-1:0] code_o
);

  localparam int unsigned DEPTH = 1 << M;
  localparam longint      QTR   = longint'(1) << (M - 2);
  localparam longint      MID   = longint'(1) << (M - 1);

  // Integer Taylor series on the first quadrant, then mirrored by quadrant
  function automatic logic [M-1:0] sine_entry(input longint idx);
    longint quad, rem, k, x, term, total, mag;
    quad  = idx >>> (M - 2);
    rem   = idx & (QTR - 1);
    k     = quad[0] ? (QTR - rem) : rem;
    x     = (k * TBL_PI_Q) / (2 * QTR);
    term  = x;
    total = x;
    for (int n = 1; n <= 6; n++) begin
      term  = -((((term * x) >>> TBL_FRAC) * x) >>> TBL_FRAC) / longint'(2 * n * (2 * n + 1));
      total = total + term;
    end
    mag = (total * (MID - 1) + (longint'(1) <<< (TBL_FRAC - 1))) >>> TBL_FRAC;
    if (mag < 0) mag = 0;
    if (mag > MID - 1) mag = MID - 1;
    if (quad >= 2) return M'(MID - mag);
    else           return M'(MID + mag);
  endfunction

  logic [M-1:0] table_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    assign table_w[gi] = sine_entry(longint'(gi));
  end

  assign code_o = table_w[addr_i];

endmodule

// File: rtl/dds_shaper.sv
`timescale 1ns/1ps
module dds_shaper
  import dds_pkg::*;
#(
  parameter int unsigned M = 10
) (
  input  logic [M-1:0] phase_i,
  input  logic         flag_i,
  input  wave_e        sel_i,
  output logic [M-1:0] code_o
);

  logic [M-1:0] sine_w;
  logic [M-1:0] tri_w;

  dds_sine_rom #(.M(M)) u_rom (
    .addr_i (phase_i),
    .code_o (sine_w)
  );

  // the flag inverts every phase bit through the XOR row
  assign tri_w = phase_i ^ {M{flag_i}};

  always_comb begin
    unique case (sel_i)
      WAVE_TRI:     code_o = tri_w;
      WAVE_SINE:    code_o = sine_w;
      WAVE_SAW,
      WAVE_SAW_ALT: code_o = phase_i;
    endcase
  end

endmodule

// File: rtl/dds_wavegen.sv
`timescale 1ns/1ps
module dds_wavegen
  import dds_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter int unsigned M = 10
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] inc_i,
  input  logic [N-1:0] phase_off_i,
  input  logic [1:0]   wave_sel_i,
  output logic [M-1:0] sample_o,
  output logic         wrap_o
);

  localparam int unsigned DROP = N - M;

  // offset add and truncation in one place
  function automatic logic [M-1:0] phase_msbs(input logic [N-1:0] a, input logic [N-1:0] b);
    return M'((a + b) >> DROP);
  endfunction

  logic [N-1:0] acc_w;
  logic         carry_w;
  logic         flag_w;
  logic [M-1:0] msb_w;
  logic [M-1:0] code_w;
  wave_e        sel_w;
  logic         past_ok_q;

  assign sel_w = wave_e'(wave_sel_i);

  dds_phase_acc #(.N(N)) u_acc (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .inc_i  (inc_i),
    .acc_o  (acc_w),
    .wrap_o (carry_w)
  );

  dds_tri_flag u_flag (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wrap_i (carry_w),
    .flag_o (flag_w)
  );

  assign msb_w = phase_msbs(acc_w, phase_off_i);

  dds_shaper #(.M(M)) u_shape (
    .phase_i (msb_w),
    .flag_i  (flag_w),
    .sel_i   (sel_w),
    .code_o  (code_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sample_o  <= '0;
      wrap_o    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      sample_o  <= code_w;
      wrap_o    <= carry_w;
      past_ok_q <= 1'b1;
    end
  end

  AST_WRAP_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok_q |-> wrap_o == $past(carry_w)); // R3

  AST_RAMP_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok_q && ($past(wave_sel_i) != 2'd1) && ($past(wave_sel_i) != 2'd2))
      |-> sample_o == $past(msb_w)); // R5

endmodule

// File: tb/sim_dds_wavegen.sv
`timescale 1ns/1ps
module sim_dds_wavegen;

  localparam int N   = 32;
  localparam int M   = 10;
  localparam int MID = 1 << (M - 1);
  localparam int TOP = (1 << M) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] inc;
  logic [N-1:0] off;
  logic [1:0]   sel;
  logic [M-1:0] sample;
  logic         wrap;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [N-1:0] m_acc;
  logic         m_flag;

  always #10 clk = ~clk;

  dds_wavegen #(.N(N), .M(M)) u0 (
    .clk_i       (clk),
    .rst_i       (rst),
    .inc_i       (inc),
    .phase_off_i (off),
    .wave_sel_i  (sel),
    .sample_o    (sample),
    .wrap_o      (wrap)
  );

  typedef struct packed {
    logic [1:0]  vsel;
    logic [31:0] vinc;
    logic [31:0] voff;
    logic [15:0] vsteps;
    logic [9:0]  vcode;
    logic        vwrap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h00C00000, 32'h00000000, 16'd5, 10'd12,   1'b0}, // R5 ramp
    '{2'd0, 32'h40000000, 32'h10000000, 16'd4, 10'd832,  1'b1}, // R4 offset
    '{2'd1, 32'h80000000, 32'h00000000, 16'd3, 10'd1023, 1'b0}, // R6 inverted after wrap
    '{2'd1, 32'h40000000, 32'h00000000, 16'd4, 10'd768,  1'b1}, // R6 rising
    '{2'd1, 32'h40000000, 32'h00000000, 16'd6, 10'd767,  1'b0}, // R6 falling
    '{2'd2, 32'h40000000, 32'h00000000, 16'd2, 10'd1023, 1'b0}, // R7 peak
    '{2'd2, 32'h40000000, 32'h00000000, 16'd4, 10'd1,    1'b1}, // R7 trough
    '{2'd2, 32'h40000000, 32'h00000000, 16'd1, 10'd512,  1'b0}, // R7 zero phase
    '{2'd3, 32'h00400000, 32'h00000000, 16'd8, 10'd7,    1'b0}, // R5 spare code
    '{2'd0, 32'hFFFFFFFF, 32'h00000000, 16'd3, 10'd1023, 1'b1}  // R3 repeated carry
  };

  task automatic check(input string req, input int got, input int exp, input int tol);
    int d;
    tests++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int model_code(input logic [N-1:0] a, input logic [N-1:0] o,
                                    input logic f, input logic [1:0] s);
    logic [N-1:0] ph;
    int p;
    real v;
    ph = a + o;
    p  = int'(ph[N-1 -: M]);
    case (s)
      2'd1: return f ? (TOP - p) : p;
      2'd2: begin
        v = real'(MID - 1) * $sin(2.0 * 3.14159265358979 * real'(p) / real'(1 << M));
        if (v >= 0.0) return MID + $rtoi(v + 0.5);
        else          return MID - $rtoi(-v + 0.5);
      end
      default: return p;
    endcase
  endfunction

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input bit chk);
    logic [N:0] s;
    int ec;
    logic ew;
    ec = model_code(m_acc, off, m_flag, sel);
    s  = {1'b0, m_acc} + {1'b0, inc};
    ew = s[N];
    m_acc  = s[N-1:0];
    m_flag = m_flag ^ ew;
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      check(tag_for(sel), int'(sample), ec, (sel == 2'd2) ? 1 : 0);
      check("R3", int'(wrap), int'(ew), 0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst    = 1'b0;
    m_acc  = '0;
    m_flag = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    inc = '0;
    off = '0;
    sel = 2'd0;
    @(negedge clk);
    do_reset();
    check("R1", int'(sample), 0, 0);
    check("R1", int'(wrap), 0, 0);

    // vector table: each row starts from reset
    for (int i = 0; i < NV; i++) begin
      do_reset();
      sel = VECS[i].vsel;
      inc = VECS[i].vinc;
      off = VECS[i].voff;
      for (int k = 0; k < int'(VECS[i].vsteps); k++) step(1'b0);
      check((VECS[i].vsel == 2'd2) ? "R7 vector" : "R8 vector",
            int'(sample), int'(VECS[i].vcode), (VECS[i].vsel == 2'd2) ? 1 : 0);
      check("R3 vector", int'(wrap), int'(VECS[i].vwrap), 0);
    end

    // R2 R8: select, step and offset changed mid-run, no phase reset
    do_reset();
    inc = 32'h01234567;
    off = 32'h0ABC0000;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int k = 0; k < 300; k++) step(1'b1);
      inc = inc + 32'h00F0F0F1;
    end

    // R3: a wrap that begins as a carry in the discarded low bits
    do_reset();
    sel = 2'd1;
    off = '0;
    inc = 32'h80000000;
    step(1'b1);
    inc = 32'h7FFFFFFF;
    step(1'b1);
    check("R3 no wrap yet", int'(wrap), 0, 0);
    inc = 32'h00000001;
    step(1'b1);
    check("R3 low-bit carry", int'(wrap), 1, 0);
    inc = 32'h00400000;
    step(1'b1);
    check("R6 flag after low-bit wrap", int'(sample), TOP, 0);

    // R7: sweep every sine entry
    do_reset();
    sel = 2'd2;
    inc = 32'h00400000;
    for (int k = 0; k < 1030; k++) step(1'b1);

    // R6: triangle over several wraps
    do_reset();
    sel = 2'd1;
    inc = 32'h04000000;
    for (int k = 0; k < 200; k++) step(1'b1);

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run", int'(sample), 0, 0);
    check("R1 mid-run", int'(wrap), 0, 0);
    rst    = 1'b0;
    m_acc  = '0;
    m_flag = 1'b0;
    sel = 2'd0;
    inc = 32'h00400000;
    step(1'b1);
    check("R1 phase restarts", int'(sample), 0, 0);
    step(1'b1);
    check("R2 first step", int'(sample), 1, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule